// File: doc/BRIEF.md
# Processor Interrupt Pin Conditioner

This block sits between a processor core and the handful of control pins that can interrupt, stop or reset it. Pin updates arrive as indexed writes, one per cycle at most, each carrying a slot index and the new level for that slot. The block keeps the last level written to every slot. It acts on a write only when the new level differs from the stored one. Each recognised pin then applies its own sensitivity rule to a pending-interrupt vector, a halt output or a core reset pulse.

The pending vector feeds a single combined interrupt request. The core clears pending bits with per-bit acknowledge strobes once it has taken the interrupt. Slots that carry no pin function only record their level. Every output is registered and shows the effect of a write or an acknowledge on the clock edge that samples it.

Top module: `pinc_core`

## Requirements
- R1: A write whose level equals the stored level of its slot has no effect on any output. Only a write that changes the stored level produces an event.
- R2: Slot 0 (external interrupt) and slot 1 (management interrupt) are active high and level sensitive. On an event, pending bit 0 or pending bit 1 takes the new level.
- R3: Slot 2 (machine check) reacts only to a high-to-low change, which sets pending bit 2. A low-to-high change leaves pending bit 2 unchanged.
- R4: Setting ack_i[k] high for a cycle clears pending bit k. If an event in the same cycle sets that bit, the set takes priority.
- R5: Slot 3 (checkstop) is active low. A change to low raises halt_o, and a change back to high lowers it.
- R6: Slot 4 (hard reset) is active low. A change to low produces a core_rst_o pulse that lasts exactly one cycle. A change to high produces no pulse.
- R7: Slot 5 (soft reset) drives pending bit 3 to the new level on an event.
- R8: irq_o is high exactly when at least one bit of pend_o is set.
- R9: A write to slot 6 or slot 7 changes no pending bit, halt_o or core_rst_o, but its level is stored and appears on pin_state_o.
- R10: After reset, pend_o, irq_o, halt_o and core_rst_o are zero. pin_state_o is high for slots 3 and 4 and low for all other slots.
- R11: Outputs reflect a write or an acknowledge on the first rising clock edge after it is presented. pin_state_o bit k holds the stored level of slot k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_wr_i | input | 1 | A pin level write is presented this cycle |
| pin_idx_i | input | IDX_W | Slot index of the write |
| pin_lvl_i | input | 1 | New level for the addressed slot |
| ack_i | input | 4 | Per-bit clear strobes for the pending vector |
| pend_o | output | 4 | Pending bits: 0 external, 1 management, 2 machine check, 3 soft reset |
| irq_o | output | 1 | Combined interrupt request |
| halt_o | output | 1 | Processor halt request |
| core_rst_o | output | 1 | One-cycle core reset pulse |
| pin_state_o | output | 2**IDX_W | Stored level of every slot |

## Verification
The bench repeats writes at the current level on every pin. A design that lost change detection would pulse core reset again, re-set a cleared machine-check bit or toggle halt. It raises machine check while low, acknowledges it and writes a new falling edge in the same cycle as an acknowledge. A design that got the priority wrong would drop the latched bit, and one that treated the pin as level sensitive would clear the bit on the rising edge. It also writes the two unused slots. Randomised writes and acknowledges then exercise all slots against the reference model. A wrong reset value for the active-low pins would make the first low write look like a repeat, so no halt or reset would follow.

// File: rtl/pinc_pkg.sv
package pinc_pkg;

    localparam int PEND_W = 4;

    // slot indices of the recognised pins
    localparam int SLOT_EXT    = 0;
    localparam int SLOT_MGMT   = 1;
    localparam int SLOT_MCHK   = 2;
    localparam int SLOT_CKSTOP = 3;
    localparam int SLOT_HRST   = 4;
    localparam int SLOT_SRST   = 5;

    // pending vector bit positions
    localparam int PB_EXT  = 0;
    localparam int PB_MGMT = 1;
    localparam int PB_MCHK = 2;
    localparam int PB_SRST = 3;

    typedef struct packed {
        logic ext_set;
        logic ext_clr;
        logic mgmt_set;
        logic mgmt_clr;
        logic mchk_fall;
        logic stop_on;
        logic stop_off;
        logic hrst_fall;
        logic srst_set;
        logic srst_clr;
    } pin_ev_t;

    function automatic logic slot_idle_level(input int slot);
        return (slot == SLOT_CKSTOP) || (slot == SLOT_HRST);
    endfunction

endpackage

// File: rtl/pinc_slot.sv
module pinc_slot #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic lvl,
    output logic q
);
    logic lvl_d, lvl_q;

    always_comb begin
        lvl_d = lvl_q;
        if (wr_en) lvl_d = lvl;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= RST_VAL;
        else        lvl_q <= lvl_d;
    end

    assign q = lvl_q;
endmodule

// File: rtl/pinc_event.sv
module pinc_event
    import pinc_pkg::*;
#(
    parameter int IDX_W = 3
) (
    input  logic             wr,
    input  logic [IDX_W-1:0] idx,
    input  logic             lvl,
    input  logic             prev,
    output pin_ev_t          ev
);
    logic chg;
    assign chg = wr && (lvl != prev);

    always_comb begin
        ev = '0;
        if (chg) begin
            case (int'(idx))
                SLOT_EXT: begin
                    ev.ext_set = lvl;
                    ev.ext_clr = !lvl;
                end
                SLOT_MGMT: begin
                    ev.mgmt_set = lvl;
                    ev.mgmt_clr = !lvl;
                end
                SLOT_MCHK:   ev.mchk_fall = !lvl;
                SLOT_CKSTOP: begin
                    ev.stop_on  = !lvl;
                    ev.stop_off = lvl;
                end
                SLOT_HRST:   ev.hrst_fall = !lvl;
                SLOT_SRST: begin
                    ev.srst_set = lvl;
                    ev.srst_clr = !lvl;
                end
                default: ev = '0;
            endcase
        end
    end
endmodule

// File: rtl/pinc_core.sv
module pinc_core
    import pinc_pkg::*;
#(
    parameter int IDX_W = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   pin_wr_i,
    input  logic [IDX_W-1:0]       pin_idx_i,
    input  logic                   pin_lvl_i,
    input  logic [PEND_W-1:0]      ack_i,
    output logic [PEND_W-1:0]      pend_o,
    output logic                   irq_o,
    output logic                   halt_o,
    output logic                   core_rst_o,
    output logic [(1<<IDX_W)-1:0]  pin_state_o
);
    localparam int NSLOT = 1 << IDX_W;

    typedef struct packed {
        logic [PEND_W-1:0] pend;
        logic              halt;
        logic              rst;
    } ctl_t;

    ctl_t            ctl_d, ctl_q;
    logic [NSLOT-1:0] slot_q;
    logic             prev_lvl;
    pin_ev_t          ev;

    for (genvar k = 0; k < NSLOT; k++) begin : g_slot
        pinc_slot #(
            .RST_VAL(slot_idle_level(k))
        ) u_slot (
            .clk  (clk),
            .rst_n(rst_n),
            .wr_en(pin_wr_i && (pin_idx_i == IDX_W'(k))),
            .lvl  (pin_lvl_i),
            .q    (slot_q[k])
        );
    end

    assign prev_lvl = slot_q[pin_idx_i];

    pinc_event #(.IDX_W(IDX_W)) u_event (
        .wr  (pin_wr_i),
        .idx (pin_idx_i),
        .lvl (pin_lvl_i),
        .prev(prev_lvl),
        .ev  (ev)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.rst  = 1'b0;
        ctl_d.pend = ctl_q.pend & ~ack_i;
        if (ev.ext_set)   ctl_d.pend[PB_EXT]  = 1'b1;
        if (ev.ext_clr)   ctl_d.pend[PB_EXT]  = 1'b0;
        if (ev.mgmt_set)  ctl_d.pend[PB_MGMT] = 1'b1;
        if (ev.mgmt_clr)  ctl_d.pend[PB_MGMT] = 1'b0;
        if (ev.mchk_fall) ctl_d.pend[PB_MCHK] = 1'b1;
        if (ev.srst_set)  ctl_d.pend[PB_SRST] = 1'b1;
        if (ev.srst_clr)  ctl_d.pend[PB_SRST] = 1'b0;
        if (ev.stop_on)   ctl_d.halt = 1'b1;
        if (ev.stop_off)  ctl_d.halt = 1'b0;
        if (ev.hrst_fall) ctl_d.rst  = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign pend_o      = ctl_q.pend;
    assign irq_o       = |ctl_q.pend;
    assign halt_o      = ctl_q.halt;
    assign core_rst_o  = ctl_q.rst;
    assign pin_state_o = slot_q;
endmodule

// File: rtl/pinc_checker.sv
module pinc_checker
    import pinc_pkg::*;
#(
    parameter int IDX_W = 3
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  pin_wr_i,
    input logic [IDX_W-1:0]      pin_idx_i,
    input logic                  pin_lvl_i,
    input logic [PEND_W-1:0]     ack_i,
    input logic [PEND_W-1:0]     pend_o,
    input logic                  irq_o,
    input logic                  halt_o,
    input logic                  core_rst_o,
    input logic [(1<<IDX_W)-1:0] pin_state_o
);
    logic same_lvl;
    assign same_lvl = pin_wr_i && (pin_lvl_i == pin_state_o[pin_idx_i]);

    // R1: repeated level with no acknowledge leaves every output unchanged
    a_r1_repeat_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
        (same_lvl && ack_i == '0) |=> ($stable(pend_o) && $stable(halt_o) && !core_rst_o));

    // R2: external interrupt pending bit follows a level change
    a_r2_ext_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_wr_i && pin_idx_i == IDX_W'(SLOT_EXT) && !same_lvl) |=> (pend_o[PB_EXT] == $past(pin_lvl_i)));

    // R3, R4: a falling machine check edge sets the bit even under acknowledge
    a_r3_mchk_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_wr_i && pin_idx_i == IDX_W'(SLOT_MCHK) && pin_state_o[SLOT_MCHK] && !pin_lvl_i) |=> pend_o[PB_MCHK]);

    // R5: halt tracks the stored checkstop level
    a_r5_halt_state: assert property (@(posedge clk) disable iff (!rst_n)
        halt_o == !pin_state_o[SLOT_CKSTOP]);

    // R6: the core reset pulse never lasts two cycles
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        core_rst_o |=> !core_rst_o);

    // R8: no request while nothing is pending
    a_r8_irq_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o == '0) |-> !irq_o);

    // R8: a request whenever a bit is pending
    a_r8_irq_any: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o != '0) |-> irq_o);
endmodule

bind pinc_core pinc_checker #(.IDX_W(IDX_W)) u_pinc_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .pin_wr_i   (pin_wr_i),
    .pin_idx_i  (pin_idx_i),
    .pin_lvl_i  (pin_lvl_i),
    .ack_i      (ack_i),
    .pend_o     (pend_o),
    .irq_o      (irq_o),
    .halt_o     (halt_o),
    .core_rst_o (core_rst_o),
    .pin_state_o(pin_state_o)
);

// File: tb/pinc_core_test.sv
`timescale 1ns/1ps
module pinc_core_test;
    localparam int IDX_W = 3;
    localparam int NS    = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           pin_wr_i = 1'b0;
    logic [2:0]     pin_idx_i = '0;
    logic           pin_lvl_i = 1'b0;
    logic [3:0]     ack_i = '0;
    logic [3:0]     pend_o;
    logic           irq_o, halt_o, core_rst_o;
    logic [NS-1:0]  pin_state_o;

    int n_run = 0;
    int n_fail = 0;

    // reference model state
    bit m_pend[4];
    bit m_halt, m_rst;
    bit m_st[NS];

    always #2.5 clk = ~clk;

    pinc_core #(.IDX_W(IDX_W)) uut (
        .clk(clk), .rst_n(rst_n), .pin_wr_i(pin_wr_i), .pin_idx_i(pin_idx_i),
        .pin_lvl_i(pin_lvl_i), .ack_i(ack_i), .pend_o(pend_o), .irq_o(irq_o),
        .halt_o(halt_o), .core_rst_o(core_rst_o), .pin_state_o(pin_state_o)
    );

    function automatic logic [14:0] model_vec();
        logic [3:0] p;
        logic [7:0] s;
        bit any = 0;
        for (int k = 0; k < 4; k++) begin p[k] = m_pend[k]; any |= m_pend[k]; end
        for (int k = 0; k < NS; k++) s[k] = m_st[k];
        return {p, any, m_halt, m_rst, s};
    endfunction

    task automatic check(input string req);
        logic [14:0] act, exp;
        act = {pend_o, irq_o, halt_o, core_rst_o, pin_state_o};
        exp = model_vec();
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int k = 0; k < 4; k++) m_pend[k] = 0;
        for (int k = 0; k < NS; k++) m_st[k] = (k == 3 || k == 4);
        m_halt = 0;
        m_rst  = 0;
    endtask

    // apply one cycle of stimulus, update model at the edge, compare after it
    task automatic step(input bit wr, input int idx, input bit lvl, input logic [3:0] ack, input string req);
        pin_wr_i  = wr;
        pin_idx_i = 3'(idx);
        pin_lvl_i = lvl;
        ack_i     = ack;
        @(posedge clk);
        m_rst = 0;
        for (int k = 0; k < 4; k++) if (ack[k]) m_pend[k] = 0;
        if (wr && lvl != m_st[idx]) begin
            case (idx)
                0: m_pend[0] = lvl;
                1: m_pend[1] = lvl;
                2: if (!lvl) m_pend[2] = 1;
                3: m_halt = !lvl;
                4: if (!lvl) m_rst = 1;
                5: m_pend[3] = lvl;
                default: ;
            endcase
            m_st[idx] = lvl;
        end
        @(negedge clk);
        pin_wr_i = 0;
        ack_i    = '0;
        check(req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL R11 watchdog actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R10");
        // R2 external and management levels, R1 repeats, R8 combined request
        step(1, 0, 1, 4'h0, "R2");
        step(1, 0, 1, 4'h0, "R1");
        step(1, 1, 1, 4'h0, "R2");
        step(1, 0, 0, 4'h0, "R2");
        step(1, 1, 0, 4'h0, "R8");
        // R4 acknowledge on a level bit
        step(1, 0, 1, 4'h0, "R4");
        step(0, 0, 0, 4'h1, "R4");
        step(1, 0, 1, 4'h0, "R1");
        step(1, 0, 0, 4'h0, "R2");
        // R3 machine check
        step(1, 2, 0, 4'h0, "R1");
        step(1, 2, 1, 4'h0, "R3");
        step(1, 2, 0, 4'h0, "R3");
        step(1, 2, 1, 4'h0, "R3");
        step(0, 0, 0, 4'h4, "R4");
        step(1, 2, 0, 4'h4, "R4");
        step(1, 2, 0, 4'h0, "R1");
        step(0, 0, 0, 4'h4, "R4");
        // R5 checkstop
        step(1, 3, 0, 4'h0, "R5");
        step(1, 3, 0, 4'h0, "R1");
        step(1, 3, 1, 4'h0, "R5");
        // R6 hard reset
        step(1, 4, 0, 4'h0, "R6");
        step(0, 0, 0, 4'h0, "R6");
        step(1, 4, 0, 4'h0, "R6");
        step(1, 4, 1, 4'h0, "R6");
        // R7 soft reset
        step(1, 5, 1, 4'h0, "R7");
        step(1, 5, 0, 4'h0, "R7");
        // R9 unused slots
        step(1, 6, 1, 4'h0, "R9");
        step(1, 7, 1, 4'h0, "R9");
        step(1, 6, 0, 4'h0, "R9");
        // mixed traffic, R11 timing of every output
        for (int i = 0; i < 400; i++) begin
            int   ix  = $urandom_range(0, 7);
            bit   lv  = 1'($urandom_range(0, 1));
            bit   w   = ($urandom_range(0, 3) != 0);
            logic [3:0] ak = ($urandom_range(0, 3) == 0) ? 4'($urandom_range(0, 15)) : 4'h0;
            step(w, ix, lv, ak, "R11");
        end
        // reset again, R10
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        check("R10");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule